// File: doc/BRIEF.md
# Byte-Lane Error-Correcting Memory with Background Scrubber

This block is an on-chip word memory that protects each byte of a stored word on its own. Every 8-bit lane is held as a 13-bit codeword: a Hamming(12,8) code plus one overall parity bit. A CPU read corrects a single flipped bit in any lane and returns per-lane flags. Two flips in one lane are flagged as uncorrectable and are never miscorrected. A CPU read that corrects data does not write it back.

A scrub sequencer runs in the background, in cycles when the CPU port is idle. It visits addresses in ascending order and wraps at the end. It decodes each word and writes back any word that had only correctable lanes. The CPU always has priority over it. Two saturating counters log corrected and uncorrectable accesses, and a sticky flag holds the address of the first uncorrectable word. A fault-injection port XORs a mask into a stored word so that a testbench can plant errors.

Top module: `lane_ecc_ram`

## Requirements
- R1: Stored bits of byte lane k occupy word bits 13k to 13k+12. A CPU read of a word with exactly one flipped bit in lane k returns the written data and sets rd_corr_o[k] with rd_unc_o[k] clear.
- R2: A CPU read of a word with two flipped bits in the same lane k sets rd_unc_o[k] and clears rd_corr_o[k]. rd_corr_o and rd_unc_o never share a set bit.
- R3: rvalid_o, rdata_o and the flags update at the clock edge after a read request (req_i=1, we_i=0). After any other cycle, rvalid_o and both flag vectors are zero.
- R4: A CPU write (req_i=1, we_i=1) stores fresh codewords only in lanes whose be_i bit is set. Other lanes, including any error they hold, are left unchanged.
- R5: After reset every word reads as zero with no flags, both counters are zero, the sticky flag is clear and scrub_addr_o is zero.
- R6: A CPU read that corrects a word does not repair it, so a second read reports the same correction.
- R7: Each scrub step moves scrub_addr_o to the next address, and the address after the last one is zero.
- R8: With scrub_en_i set and the CPU idle, clean words are visited once every scrub_gap_i+1 cycles.
- R9: When the scrubber finds a word whose lanes are all clean or correctable, with at least one correction, it writes the corrected word back. It spends one extra cycle on that word and counts one corrected event. A word with an uncorrectable lane is counted and skipped, not written back.
- R10: While req_i is high, scrub_addr_o does not change.
- R11: If the scrubber is holding a corrected word and the CPU writes to that same address, the writeback is abandoned. The address does not advance, and the CPU data is kept.
- R12: Each CPU read or scrub step adds one to unc_cnt_o if any lane is uncorrectable. Otherwise it adds one to corr_cnt_o if any lane was corrected. Both counters saturate at their maximum and never decrease except on a clear.
- R13: unc_flag_o sets on the first uncorrectable event, and unc_addr_o then holds that address until err_clr_i. A cycle with err_clr_i set zeroes both counters and the flag; events in that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | CPU access request |
| we_i | input | 1 | CPU write when set, read when clear |
| be_i | input | DATA_W/8 | Per-byte write enables |
| addr_i | input | AW | CPU word address |
| wdata_i | input | DATA_W | CPU write data |
| rvalid_o | output | 1 | Read result valid |
| rdata_o | output | DATA_W | Corrected read data |
| rd_corr_o | output | DATA_W/8 | Lanes corrected on this read |
| rd_unc_o | output | DATA_W/8 | Lanes uncorrectable on this read |
| scrub_en_i | input | 1 | Scrubber enable |
| scrub_gap_i | input | GAP_W | Idle cycles between scrub steps |
| scrub_addr_o | output | AW | Next address the scrubber visits |
| corr_cnt_o | output | CNT_W | Saturating corrected-event count |
| unc_cnt_o | output | CNT_W | Saturating uncorrectable-event count |
| unc_flag_o | output | 1 | Sticky uncorrectable flag |
| unc_addr_o | output | AW | Address of first uncorrectable event |
| err_clr_i | input | 1 | Clear counters and sticky flag |
| inj_en_i | input | 1 | Apply fault mask this cycle |
| inj_addr_i | input | AW | Word to receive the fault mask |
| inj_mask_i | input | 13*DATA_W/8 | Stored bits to flip |

## Verification
The case that needs care is a scrub writeback and a CPU write landing on the same word in adjacent cycles. The bench plants a single-bit fault at the address the scrubber will visit next. It enables the scrubber with a zero gap for exactly one cycle, so the word is read and held for writeback. In the following cycle it issues a full-word CPU write to that address. The outcome is judged by reading the word back, which must hold the CPU's data with no correction flag, and by checking that scrub_addr_o has stayed on that word. A scrubber that wrote its stale copy afterward would return the old data.

// File: rtl/lane_ecc_pkg.sv
package lane_ecc_pkg;
  localparam int LANE_W = 8;
  localparam int CW_W   = 13;

  typedef logic [CW_W-1:0] cw_t;

  typedef struct packed {
    logic [LANE_W-1:0] data;
    logic              corr;
    logic              unc;
  } lane_res_t;

  // cw[12:1] = Hamming positions 1..12 (checks at 1,2,4,8), cw[0] = overall parity
  function automatic cw_t lane_enc(input logic [LANE_W-1:0] d);
    cw_t c;
    c     = '0;
    c[3]  = d[0];
    c[5]  = d[1];
    c[6]  = d[2];
    c[7]  = d[3];
    c[9]  = d[4];
    c[10] = d[5];
    c[11] = d[6];
    c[12] = d[7];
    c[1]  = c[3] ^ c[5] ^ c[7] ^ c[9] ^ c[11];
    c[2]  = c[3] ^ c[6] ^ c[7] ^ c[10] ^ c[11];
    c[4]  = c[5] ^ c[6] ^ c[7] ^ c[12];
    c[8]  = c[9] ^ c[10] ^ c[11] ^ c[12];
    c[0]  = ^c[12:1];
    return c;
  endfunction

  function automatic lane_res_t lane_dec(input cw_t c);
    lane_res_t r;
    logic [3:0] syn;
    logic       par;
    cw_t        f;
    syn = '0;
    for (int i = 1; i < CW_W; i++) begin
      if (c[i]) syn = syn ^ 4'(i);
    end
    par    = ^c;
    f      = c;
    r.corr = 1'b0;
    r.unc  = 1'b0;
    if (par) begin
      if (syn > 4'd12) begin
        r.unc = 1'b1;
      end else begin
        r.corr = 1'b1;
        if (syn != 4'd0) f[syn] = ~f[syn];
      end
    end else if (syn != 4'd0) begin
      r.unc = 1'b1;
    end
    r.data = {f[12], f[11], f[10], f[9], f[7], f[6], f[5], f[3]};
    return r;
  endfunction
endpackage

// File: rtl/lane_ecc_word_dec.sv
module lane_ecc_word_dec
  import lane_ecc_pkg::*;
#(
  parameter int LANES = 4,
  localparam int WORD_W = LANES * CW_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic [WORD_W-1:0] cw_i,
  output logic [DATA_W-1:0] data_o,
  output logic [LANES-1:0]  corr_o,
  output logic [LANES-1:0]  unc_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lane_res_t res;
    assign res = lane_dec(cw_i[l*CW_W +: CW_W]);
    assign data_o[l*LANE_W +: LANE_W] = res.data;
    assign corr_o[l] = res.corr;
    assign unc_o[l]  = res.unc;
  end
endmodule

// File: rtl/lane_ecc_store.sv
module lane_ecc_store
  import lane_ecc_pkg::*;
#(
  parameter int AW    = 4,
  parameter int LANES = 4,
  localparam int DEPTH  = 2 ** AW,
  localparam int WORD_W = LANES * CW_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [LANES-1:0]  wr_be_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              inj_en_i,
  input  logic [AW-1:0]     inj_addr_i,
  input  logic [WORD_W-1:0] inj_mask_i,
  input  logic [AW-1:0]     ra_addr_i,
  output logic [WORD_W-1:0] ra_cw_o,
  input  logic [AW-1:0]     rb_addr_i,
  output logic [WORD_W-1:0] rb_cw_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [WORD_W-1:0] mem_d [DEPTH];
  logic [WORD_W-1:0] enc_cw;

  for (genvar l = 0; l < LANES; l++) begin : g_enc
    assign enc_cw[l*CW_W +: CW_W] = lane_enc(wr_data_i[l*LANE_W +: LANE_W]);
  end

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_comb begin
      mem_d[w] = mem_q[w];
      if (wr_en_i && wr_addr_i == AW'(w)) begin
        for (int l = 0; l < LANES; l++) begin
          if (wr_be_i[l]) mem_d[w][l*CW_W +: CW_W] = enc_cw[l*CW_W +: CW_W];
        end
      end
      if (inj_en_i && inj_addr_i == AW'(w)) mem_d[w] = mem_d[w] ^ inj_mask_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[w] <= '0;
      else         mem_q[w] <= mem_d[w];
    end
  end

  assign ra_cw_o = mem_q[ra_addr_i];
  assign rb_cw_o = mem_q[rb_addr_i];
endmodule

// File: rtl/lane_ecc_scrub.sv
module lane_ecc_scrub #(
  parameter int AW     = 4,
  parameter int LANES  = 4,
  parameter int GAP_W  = 8,
  localparam int DATA_W = LANES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [GAP_W-1:0]  gap_i,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [AW-1:0]     cpu_addr_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [LANES-1:0]  rd_corr_i,
  input  logic [LANES-1:0]  rd_unc_i,
  output logic [AW-1:0]     addr_o,
  output logic              wb_en_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              ev_corr_o,
  output logic              ev_unc_o
);
  typedef enum logic {ST_WAIT, ST_HOLD} st_e;

  st_e               st_q, st_d;
  logic [GAP_W-1:0]  cnt_q, cnt_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              any_unc, any_corr;

  assign any_unc  = |rd_unc_i;
  assign any_corr = |rd_corr_i;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    addr_d    = addr_q;
    data_d    = data_q;
    wb_en_o   = 1'b0;
    ev_corr_o = 1'b0;
    ev_unc_o  = 1'b0;
    unique case (st_q)
      ST_WAIT: begin
        if (!en_i) begin
          cnt_d = '0;
        end else if (!cpu_req_i) begin
          if (cnt_q >= gap_i) begin
            cnt_d     = '0;
            ev_unc_o  = any_unc;
            ev_corr_o = any_corr && !any_unc;
            if (any_corr && !any_unc) begin
              data_d = rd_data_i;
              st_d   = ST_HOLD;
            end else begin
              addr_d = addr_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (cpu_req_i) begin
          // CPU overwrite of the held word makes the copy stale: retry later
          if (cpu_we_i && cpu_addr_i == addr_q) st_d = ST_WAIT;
        end else begin
          wb_en_o = 1'b1;
          addr_d  = addr_q + 1'b1;
          st_d    = ST_WAIT;
        end
      end
      default: st_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_WAIT;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign addr_o    = addr_q;
  assign wb_data_o = data_q;
endmodule

// File: rtl/lane_ecc_errlog.sv
module lane_ecc_errlog #(
  parameter int AW    = 4,
  parameter int CNT_W = 8,
  parameter int SRCS  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic [SRCS-1:0]     ev_corr_i,
  input  logic [SRCS-1:0]     ev_unc_i,
  input  logic [SRCS*AW-1:0]  ev_addr_i,
  output logic [CNT_W-1:0]    corr_cnt_o,
  output logic [CNT_W-1:0]    unc_cnt_o,
  output logic                unc_flag_o,
  output logic [AW-1:0]       unc_addr_o
);
  localparam int INC_W = $clog2(SRCS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q [2];
  logic [SRCS-1:0]  ev [2];
  logic             flag_q;
  logic [AW-1:0]    uaddr_q, uaddr_d;

  assign ev[0] = ev_corr_i;
  assign ev[1] = ev_unc_i;

  for (genvar k = 0; k < 2; k++) begin : g_cnt
    logic [INC_W-1:0] inc;
    logic [CNT_W:0]   sum;
    assign inc = INC_W'($countones(ev[k]));
    assign sum = {1'b0, cnt_q[k]} + (CNT_W + 1)'(inc);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q[k] <= '0;
      else if (clr_i)    cnt_q[k] <= '0;
      else if (sum[CNT_W]) cnt_q[k] <= CNT_MAX;
      else               cnt_q[k] <= sum[CNT_W-1:0];
    end
  end

  // lowest-numbered source wins the sticky address
  always_comb begin
    uaddr_d = uaddr_q;
    for (int s = SRCS - 1; s >= 0; s--) begin
      if (ev_unc_i[s]) uaddr_d = ev_addr_i[s*AW +: AW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      uaddr_q <= '0;
    end else if (clr_i) begin
      flag_q  <= 1'b0;
      uaddr_q <= '0;
    end else if (!flag_q && |ev_unc_i) begin
      flag_q  <= 1'b1;
      uaddr_q <= uaddr_d;
    end
  end

  assign corr_cnt_o = cnt_q[0];
  assign unc_cnt_o  = cnt_q[1];
  assign unc_flag_o = flag_q;
  assign unc_addr_o = uaddr_q;
endmodule

// File: rtl/lane_ecc_ram.sv
module lane_ecc_ram #(
  parameter int AW     = 4,
  parameter int DATA_W = 32,
  parameter int GAP_W  = 8,
  parameter int CNT_W  = 8,
  localparam int LANES  = DATA_W / 8,
  localparam int WORD_W = LANES * lane_ecc_pkg::CW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [LANES-1:0]  rd_corr_o,
  output logic [LANES-1:0]  rd_unc_o,
  input  logic              scrub_en_i,
  input  logic [GAP_W-1:0]  scrub_gap_i,
  output logic [AW-1:0]     scrub_addr_o,
  output logic [CNT_W-1:0]  corr_cnt_o,
  output logic [CNT_W-1:0]  unc_cnt_o,
  output logic              unc_flag_o,
  output logic [AW-1:0]     unc_addr_o,
  input  logic              err_clr_i,
  input  logic              inj_en_i,
  input  logic [AW-1:0]     inj_addr_i,
  input  logic [WORD_W-1:0] inj_mask_i
);
  logic              cpu_rd, cpu_wr;
  logic [WORD_W-1:0] cpu_cw, scr_cw;
  logic [DATA_W-1:0] cpu_dat, scr_dat, scr_wb_dat;
  logic [LANES-1:0]  cpu_corr, cpu_unc, scr_corr, scr_unc;
  logic              scr_wb, scr_ev_corr, scr_ev_unc;
  logic [AW-1:0]     scr_addr;
  logic              st_wr_en;
  logic [AW-1:0]     st_wr_addr;
  logic [LANES-1:0]  st_wr_be;
  logic [DATA_W-1:0] st_wr_data;

  assign cpu_rd = req_i && !we_i;
  assign cpu_wr = req_i && we_i;

  assign st_wr_en   = cpu_wr || scr_wb;
  assign st_wr_addr = cpu_wr ? addr_i  : scr_addr;
  assign st_wr_be   = cpu_wr ? be_i    : '1;
  assign st_wr_data = cpu_wr ? wdata_i : scr_wb_dat;

  lane_ecc_store #(.AW(AW), .LANES(LANES)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i(st_wr_en), .wr_addr_i(st_wr_addr), .wr_be_i(st_wr_be), .wr_data_i(st_wr_data),
    .inj_en_i, .inj_addr_i, .inj_mask_i,
    .ra_addr_i(addr_i),   .ra_cw_o(cpu_cw),
    .rb_addr_i(scr_addr), .rb_cw_o(scr_cw)
  );

  lane_ecc_word_dec #(.LANES(LANES)) u_dec_cpu (
    .cw_i(cpu_cw), .data_o(cpu_dat), .corr_o(cpu_corr), .unc_o(cpu_unc)
  );

  lane_ecc_word_dec #(.LANES(LANES)) u_dec_scr (
    .cw_i(scr_cw), .data_o(scr_dat), .corr_o(scr_corr), .unc_o(scr_unc)
  );

  lane_ecc_scrub #(.AW(AW), .LANES(LANES), .GAP_W(GAP_W)) u_scrub (
    .clk_i, .rst_ni,
    .en_i(scrub_en_i), .gap_i(scrub_gap_i),
    .cpu_req_i(req_i), .cpu_we_i(we_i), .cpu_addr_i(addr_i),
    .rd_data_i(scr_dat), .rd_corr_i(scr_corr), .rd_unc_i(scr_unc),
    .addr_o(scr_addr), .wb_en_o(scr_wb), .wb_data_o(scr_wb_dat),
    .ev_corr_o(scr_ev_corr), .ev_unc_o(scr_ev_unc)
  );

  lane_ecc_errlog #(.AW(AW), .CNT_W(CNT_W), .SRCS(2)) u_log (
    .clk_i, .rst_ni,
    .clr_i(err_clr_i),
    .ev_corr_i({scr_ev_corr, cpu_rd && |cpu_corr && !(|cpu_unc)}),
    .ev_unc_i ({scr_ev_unc,  cpu_rd && |cpu_unc}),
    .ev_addr_i({scr_addr, addr_i}),
    .corr_cnt_o, .unc_cnt_o, .unc_flag_o, .unc_addr_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o  <= 1'b0;
      rdata_o   <= '0;
      rd_corr_o <= '0;
      rd_unc_o  <= '0;
    end else begin
      rvalid_o  <= cpu_rd;
      rd_corr_o <= cpu_rd ? cpu_corr : '0;
      rd_unc_o  <= cpu_rd ? cpu_unc  : '0;
      if (cpu_rd) rdata_o <= cpu_dat;
    end
  end

  assign scrub_addr_o = scr_addr;
endmodule

// File: rtl/lane_ecc_ram_chk.sv
module lane_ecc_ram_chk #(
  parameter int AW    = 4,
  parameter int LANES = 4,
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic             rvalid_o,
  input logic [LANES-1:0] rd_corr_o,
  input logic [LANES-1:0] rd_unc_o,
  input logic [AW-1:0]    scrub_addr_o,
  input logic [CNT_W-1:0] corr_cnt_o,
  input logic [CNT_W-1:0] unc_cnt_o,
  input logic             unc_flag_o,
  input logic [AW-1:0]    unc_addr_o,
  input logic             err_clr_i
);
  assert_read_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> (!rvalid_o && rd_corr_o == '0 && rd_unc_o == '0));

  assert_flags_disjoint_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_corr_o & rd_unc_o) == '0);

  assert_cpu_priority_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> scrub_addr_o == $past(scrub_addr_o));

  assert_corr_no_decrease_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_clr_i |=> corr_cnt_o >= $past(corr_cnt_o));

  assert_unc_no_decrease_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_clr_i |=> unc_cnt_o >= $past(unc_cnt_o));

  assert_sticky_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unc_flag_o && !err_clr_i) |=> (unc_flag_o && $stable(unc_addr_o)));

  assert_clear_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i |=> (corr_cnt_o == '0 && unc_cnt_o == '0 && !unc_flag_o));
endmodule

bind lane_ecc_ram lane_ecc_ram_chk #(.AW(AW), .LANES(LANES), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .rvalid_o(rvalid_o), .rd_corr_o(rd_corr_o), .rd_unc_o(rd_unc_o),
  .scrub_addr_o(scrub_addr_o), .corr_cnt_o(corr_cnt_o), .unc_cnt_o(unc_cnt_o),
  .unc_flag_o(unc_flag_o), .unc_addr_o(unc_addr_o), .err_clr_i(err_clr_i)
);

// File: tb/lane_ecc_ram_tb_top.sv
module lane_ecc_ram_tb_top;
  localparam int AW = 4, DW = 32, LN = 4, WW = 52, GW = 8, CW = 8, DEPTH = 16;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req = 0, we = 0;
  logic [LN-1:0] be = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          rvalid;
  logic [DW-1:0] rdata;
  logic [LN-1:0] rcorr, runc;
  logic          sen = 0;
  logic [GW-1:0] sgap = '0;
  logic [AW-1:0] saddr;
  logic [CW-1:0] ccnt, ucnt;
  logic          uflag;
  logic [AW-1:0] uaddr;
  logic          eclr = 0, ien = 0;
  logic [AW-1:0] iaddr = '0;
  logic [WW-1:0] imask = '0;

  lane_ecc_ram dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .be_i(be), .addr_i(addr),
    .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata), .rd_corr_o(rcorr), .rd_unc_o(runc),
    .scrub_en_i(sen), .scrub_gap_i(sgap), .scrub_addr_o(saddr), .corr_cnt_o(ccnt),
    .unc_cnt_o(ucnt), .unc_flag_o(uflag), .unc_addr_o(uaddr), .err_clr_i(eclr),
    .inj_en_i(ien), .inj_addr_i(iaddr), .inj_mask_i(imask)
  );

  // 20 time units per period: 50 MHz with 1 ns units
  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [LN-1:0] b);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d; be = b;
    @(negedge clk);
    req = 0; we = 0; be = '0;
    check("R3 no valid after write", 64'(rvalid), 64'd0);
  endtask

  task automatic cpu_read(input logic [AW-1:0] a, output logic [DW-1:0] d,
                          output logic [LN-1:0] c, output logic [LN-1:0] u);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0;
    check("R3 rvalid after read", 64'(rvalid), 64'd1);
    d = rdata; c = rcorr; u = runc;
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [WW-1:0] m);
    @(negedge clk);
    ien = 1; iaddr = a; imask = m;
    @(negedge clk);
    ien = 0; imask = '0;
  endtask

  task automatic err_clear();
    @(negedge clk);
    eclr = 1;
    @(negedge clk);
    eclr = 0;
  endtask

  function automatic logic [WW-1:0] bitm(input int p);
    logic [WW-1:0] m;
    m = '0;
    m[p] = 1'b1;
    return m;
  endfunction

  function automatic logic [DW-1:0] pat(input int a);
    return (32'h0101_0101 * 32'(a)) ^ 32'hC3A5_5A3C;
  endfunction

  initial begin
    logic [DW-1:0] d, dexp;
    logic [LN-1:0] c, u;
    logic [AW-1:0] a, first_unc, a0, prev;
    int idx, n;
    bit got_first;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R5 reset state
    check("R5 corr_cnt", 64'(ccnt), 0);
    check("R5 unc_cnt", 64'(ucnt), 0);
    check("R5 unc_flag", 64'(uflag), 0);
    check("R5 scrub_addr", 64'(saddr), 0);
    check("R3 rvalid idle", 64'(rvalid), 0);
    cpu_read(4'd5, d, c, u);
    check("R5 reset data", 64'(d), 0);
    check("R5 reset flags", 64'({c, u}), 0);

    // R4 byte enables keep untouched lanes and their errors
    cpu_write(4'd3, 32'hA1B2_C3D4, 4'hF);
    inject(4'd3, bitm(13 * 2 + 4));
    cpu_write(4'd3, 32'h0000_00EE, 4'b0001);
    cpu_read(4'd3, d, c, u);
    check("R4 partial data", 64'(d), 64'hA1B2_C3EE);
    check("R4 old error kept", 64'(c), 64'b0100);
    cpu_write(4'd3, 32'h0055_0000, 4'b0100);
    cpu_read(4'd3, d, c, u);
    check("R4 rewritten lane", 64'(d), 64'hA155_C3EE);
    check("R4 fresh lane clean", 64'({c, u}), 0);

    // R6 read correction does not repair
    err_clear();
    inject(4'd7, bitm(13 * 1 + 9));
    cpu_read(4'd7, d, c, u);
    check("R6 first read corr", 64'(c), 64'b0010);
    cpu_read(4'd7, d, c, u);
    check("R6 second read corr", 64'(c), 64'b0010);
    check("R6 R12 corr_cnt", 64'(ccnt), 2);

    // R1 every single flip, R2 every double flip within a lane
    err_clear();
    idx = 0;
    for (int l = 0; l < LN; l++) begin
      for (int b = 0; b < 13; b++) begin
        a = AW'(idx);
        dexp = 32'(idx) * 32'h9E37_79B9 + 32'h0123_4567;
        cpu_write(a, dexp, 4'hF);
        inject(a, bitm(13 * l + b));
        cpu_read(a, d, c, u);
        check("R1 data", 64'(d), 64'(dexp));
        check("R1 corr lane", 64'(c), 64'(4'b1 << l));
        check("R1 no unc", 64'(u), 0);
        idx++;
      end
    end
    got_first = 0;
    first_unc = '0;
    for (int l = 0; l < LN; l++) begin
      for (int b1 = 0; b1 < 13; b1++) begin
        for (int b2 = b1 + 1; b2 < 13; b2++) begin
          a = AW'(idx);
          if (!got_first) begin first_unc = a; got_first = 1; end
          cpu_write(a, 32'(idx) ^ 32'h5A5A_0F0F, 4'hF);
          inject(a, bitm(13 * l + b1) | bitm(13 * l + b2));
          cpu_read(a, d, c, u);
          check("R2 unc lane", 64'(u), 64'(4'b1 << l));
          check("R2 no corr", 64'(c), 0);
          idx++;
        end
      end
    end
    check("R12 corr_cnt 52", 64'(ccnt), 52);
    check("R12 unc_cnt saturated", 64'(ucnt), 255);
    check("R13 flag set", 64'(uflag), 1);
    check("R13 first address", 64'(uaddr), 64'(first_unc));
    err_clear();
    check("R13 clear counts", 64'({ccnt, ucnt}), 0);
    check("R13 clear flag", 64'(uflag), 0);

    // R9 scrub repair
    for (int w = 0; w < DEPTH; w++) cpu_write(AW'(w), pat(w), 4'hF);
    inject(4'd1, bitm(0));
    inject(4'd4, bitm(13 + 7));
    inject(4'd9, bitm(26 + 12));
    inject(4'd14, bitm(39 + 3));
    inject(4'd6, bitm(13 + 2) | bitm(13 + 9));
    err_clear();
    @(negedge clk);
    sgap = 8'd0; sen = 1;
    repeat (100) @(negedge clk);
    sen = 0;
    repeat (3) @(negedge clk);
    check("R9 corr_cnt", 64'(ccnt), 4);
    check("R9 unc counted", 64'(ucnt != 0), 1);
    check("R9 R13 unc addr", 64'({uflag, uaddr}), 64'({1'b1, 4'd6}));
    for (int w = 0; w < DEPTH; w++) begin
      cpu_read(AW'(w), d, c, u);
      if (w == 6) begin
        check("R9 unc not rewritten", 64'(u), 64'b0010);
      end else begin
        check("R9 data", 64'(d), 64'(pat(w)));
        check("R9 repaired", 64'({c, u}), 0);
      end
    end

    // R7 sequence, R8 gap timing
    cpu_write(4'd6, pat(6), 4'hF);
    err_clear();
    for (int gi = 0; gi < 3; gi++) begin
      @(negedge clk);
      sgap = (gi == 0) ? 8'd0 : (gi == 1) ? 8'd3 : 8'd7;
      sen = 1;
      prev = saddr;
      n = 0;
      while (saddr == prev && n < 100) begin @(negedge clk); n++; end
      for (int s = 0; s < 18; s++) begin
        prev = saddr;
        n = 0;
        do begin @(negedge clk); n++; end while (saddr == prev && n < 100);
        check("R8 step period", 64'(n), 64'(sgap) + 1);
        check("R7 next address", 64'(saddr), 64'(AW'(prev + 1'b1)));
      end
      sen = 0;
      repeat (3) @(negedge clk);
    end

    // R10 CPU priority
    @(negedge clk);
    sgap = 8'd0; sen = 1; req = 1; we = 0; addr = 4'd0;
    a0 = saddr;
    repeat (40) @(negedge clk);
    check("R10 addr held", 64'(saddr), 64'(a0));
    req = 0;
    repeat (10) @(negedge clk);
    check("R10 resumes", 64'(saddr != a0), 1);
    sen = 0;
    repeat (3) @(negedge clk);

    // R11 writeback collision
    a = saddr;
    cpu_write(a, 32'hDEAD_BEEF, 4'hF);
    inject(a, bitm(39 + 5));
    err_clear();
    @(negedge clk);
    sgap = 8'd0; sen = 1;
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = 32'h1357_9BDF; be = 4'hF; sen = 0;
    @(negedge clk);
    req = 0; we = 0; be = '0;
    repeat (3) @(negedge clk);
    check("R11 addr kept", 64'(saddr), 64'(a));
    check("R11 R9 scrub event", 64'(ccnt), 1);
    cpu_read(a, d, c, u);
    check("R11 CPU data kept", 64'(d), 64'h1357_9BDF);
    check("R11 clean", 64'({c, u}), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule